// File: doc/BRIEF.md
# Sixteen-Pin Output Port with Atomic Set and Clear Registers

This block is a general-purpose I/O port seen through a 32-bit register bus that accepts only aligned full-word accesses. It drives sixteen output pins from an output latch and makes sixteen input pins readable after a two-stage synchronizer. Software can load the output latch as a whole word. It can also change chosen bits without first reading the latch.

The atomic path is a combined set/clear register. The lower half of a written word raises output bits and the upper half lowers them, all in one bus write. A second register only lowers the bits written as 1. A multi-bit field can therefore be placed on a group of pins in one write, with every other pin left alone. No interrupt can land between a read and a modify, because neither is needed.

Byte and half-word accesses, and word accesses to an address that is not word aligned, change nothing and raise an error flag. Read data and the error flag are registered and are valid in the cycle after the access.

Top module: `gpio_sr_port`

## Requirements
- R1: While reset is high and after it falls, `pin_out`, `bus_rdata` and `bus_err` are all zero.
- R2: An access with `bus_size` other than 2 (0 = byte, 1 = half-word, 2 = word), or with `bus_addr[1:0]` nonzero, leaves `pin_out` unchanged. It raises `bus_err` for one cycle and returns zero read data.
- R3: A word write to offset 0x4 loads `bus_wdata[15:0]` into the output latch, ignoring the upper half. A read of offset 0x4 returns the latch in bits 15:0 with zeros above.
- R4: A word write to offset 0x8 drives high every output bit whose matching bit in `bus_wdata[15:0]` is 1.
- R5: A word write to offset 0x8 drives low every output bit n for which `bus_wdata[16+n]` is 1.
- R6: When a write to offset 0x8 has both bit n and bit 16+n set, output bit n ends high.
- R7: Zero bits written to offset 0x8 or 0xC leave the matching output bits unchanged.
- R8: A word write to offset 0xC drives low every output bit whose matching bit in `bus_wdata[15:0]` is 1.
- R9: Reads of offsets 0x8 and 0xC return zero. Writes to offset 0x0 have no effect on `pin_out`.
- R10: A read of offset 0x0 returns the pin levels through two synchronizer flops. A read captured at the first or second rising edge after `pin_in` changes shows the old level. A read captured at the third edge shows the new level.
- R11: Writing 0x7F800000 OR (v << 7) to offset 0x8 puts the 8-bit value v on pins 7 to 14 in one write and leaves every other pin unchanged.
- R12: `bus_rdata` and `bus_err` change only at the rising edge that follows an access. Both are zero in any cycle that does not follow a read or an access error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_size | input | 2 | Access size: 0 byte, 1 half-word, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | Access error, registered |
| pin_in | input | 16 | Pin levels from the pads |
| pin_out | output | 16 | Output latch driving the pads |

## Verification
Each bus access is applied for one cycle and is captured at the next rising edge. `pin_out`, `bus_rdata` and `bus_err` are therefore all due one edge after the access. The bench drives on falling edges and samples at the following falling edge, which is exactly that point.

Synchronized inputs are due two edges after a pin change, so the value a read captures changes at the third edge. The bench holds a read open and samples after each of the first three edges to check both the delay and its end.

// File: rtl/gpio_sr_pkg.sv
package gpio_sr_pkg;

    // access size encoding on the bus
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;

    // register slot selected by address bits [3:2]
    typedef enum logic [1:0] {
        SEL_IN  = 2'd0,
        SEL_OUT = 2'd1,
        SEL_SC  = 2'd2,
        SEL_CLR = 2'd3
    } reg_sel_e;

    // decoded view of one bus cycle
    typedef struct packed {
        logic     wr_ok;
        logic     rd_ok;
        logic     bad;
        reg_sel_e sel;
    } bus_dec_t;

    // write enables presented to the output latch
    typedef struct packed {
        logic load;
        logic setclr;
        logic clr;
    } out_we_t;

endpackage

// File: rtl/gpio_sr_decode.sv
module gpio_sr_decode
    import gpio_sr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        size,
    output bus_dec_t          dec,
    output out_we_t           we
);
    localparam int SEL_LSB = 2;

    logic hit;
    logic aligned;
    logic active;

    // addresses above the four register slots are not decoded
    generate
        if (ADDR_W > SEL_LSB + 2) begin : g_upper
            assign hit = ~|addr[ADDR_W-1:SEL_LSB+2];
        end else begin : g_exact
            assign hit = 1'b1;
        end
    endgenerate

    assign aligned = (addr[SEL_LSB-1:0] == '0);
    assign active  = wr | rd;

    always_comb begin
        dec.sel   = reg_sel_e'(addr[SEL_LSB+1:SEL_LSB]);
        dec.bad   = active & ((size != SZ_WORD) | ~aligned);
        dec.wr_ok = wr & ~dec.bad & hit;
        dec.rd_ok = rd & ~dec.bad & hit;
    end

    always_comb begin
        we.load   = dec.wr_ok & (dec.sel == SEL_OUT);
        we.setclr = dec.wr_ok & (dec.sel == SEL_SC);
        we.clr    = dec.wr_ok & (dec.sel == SEL_CLR);
    end

endmodule

// File: rtl/gpio_sr_sync.sv
module gpio_sr_sync #(
    parameter int PIN_W  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PIN_W-1:0] d,
    output logic [PIN_W-1:0] q
);
    logic [PIN_W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/gpio_sr_outreg.sv
module gpio_sr_outreg
    import gpio_sr_pkg::*;
#(
    parameter int PIN_W = 16,
    localparam int BUS_W = 2 * PIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  out_we_t          we,
    input  logic [BUS_W-1:0] wdata,
    output logic [PIN_W-1:0] out_q
);
    logic [PIN_W-1:0] lo_bits;
    logic [PIN_W-1:0] hi_bits;
    logic [PIN_W-1:0] out_d;

    assign lo_bits = wdata[PIN_W-1:0];
    assign hi_bits = wdata[BUS_W-1:PIN_W];

    // clear first, then set: set wins on a bit named in both halves
    always_comb begin
        out_d = out_q;
        if (we.load)        out_d = lo_bits;
        else if (we.setclr) out_d = (out_q & ~hi_bits) | lo_bits;
        else if (we.clr)    out_d = out_q & ~lo_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    a_r4_set_bits_high: assert property (@(posedge clk) disable iff (rst)
        we.setclr |=> ((out_q & $past(lo_bits)) == $past(lo_bits)));

    a_r5_clear_bits_low: assert property (@(posedge clk) disable iff (rst)
        we.setclr |=> ((out_q & $past(hi_bits & ~lo_bits)) == '0));

    a_r7_zero_bits_kept: assert property (@(posedge clk) disable iff (rst)
        (we.setclr || we.clr) |=>
            (((out_q ^ $past(out_q)) & ~$past(lo_bits | (we.setclr ? hi_bits : '0))) == '0));

    a_r8_clr_only: assert property (@(posedge clk) disable iff (rst)
        we.clr |=> ((out_q & $past(lo_bits)) == '0));

    a_r2_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
        !(we.load || we.setclr || we.clr) |=> $stable(out_q));

endmodule

// File: rtl/gpio_sr_port.sv
module gpio_sr_port
    import gpio_sr_pkg::*;
#(
    parameter int PIN_W  = 16,
    parameter int ADDR_W = 4,
    localparam int BUS_W = 2 * PIN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_size,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              bus_err,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out
);
    bus_dec_t         dec;
    out_we_t          we;
    logic [PIN_W-1:0] in_sync;
    logic [PIN_W-1:0] out_q;
    logic [BUS_W-1:0] rd_mux;
    logic [BUS_W-1:0] rdata_q;
    logic             err_q;

    gpio_sr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .size (bus_size),
        .dec  (dec),
        .we   (we)
    );

    gpio_sr_sync #(.PIN_W(PIN_W), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (in_sync)
    );

    gpio_sr_outreg #(.PIN_W(PIN_W)) u_outreg (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .wdata (bus_wdata),
        .out_q (out_q)
    );

    // write-only slots read as zero
    always_comb begin
        unique case (dec.sel)
            SEL_IN:  rd_mux = {{PIN_W{1'b0}}, in_sync};
            SEL_OUT: rd_mux = {{PIN_W{1'b0}}, out_q};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            rdata_q <= dec.rd_ok ? rd_mux : '0;
            err_q   <= dec.bad;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
    assign pin_out   = out_q;

    a_r2_subword_flags_error: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && (bus_size != SZ_WORD)) |=> (bus_err && bus_rdata == '0));

    a_r2_subword_keeps_pins: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (bus_size != SZ_WORD)) |=> $stable(pin_out));

    a_r9_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr[3] && bus_size == SZ_WORD) |=> (bus_rdata == '0));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr || bus_rd) |=> (!bus_err && bus_rdata == '0));

    a_r3_upper_read_zero: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (bus_rdata[BUS_W-1:PIN_W] == '0));

endmodule

// File: tb/gpio_sr_port_bench.sv
module gpio_sr_port_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_size = 2'd2;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [15:0] exp_out = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_sr_port u_gpio_sr_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // starts at a falling edge, ends at the next one with results due
    task automatic bus_op(input logic w, input logic r, input logic [3:0] a,
                          input logic [1:0] sz, input logic [31:0] d);
        bus_wr = w; bus_rd = r; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0; bus_size = 2'd2;
    endtask

    task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
        bus_op(1'b1, 1'b0, a, 2'd2, d);
    endtask

    task automatic rd_word(input logic [3:0] a);
        bus_op(1'b0, 1'b1, a, 2'd2, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        chk("R1 pin_out in reset", {16'h0, pin_out}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pin_out after reset", {16'h0, pin_out}, 32'h0);
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        chk("R1 err after reset", {31'h0, bus_err}, 32'h0);

        // R3 direct load ignores upper half
        wr_word(4'h4, 32'hFFFF_A5C3); exp_out = 16'hA5C3;
        chk("R3 load pins", {16'h0, pin_out}, {16'h0, exp_out});
        rd_word(4'h4);
        chk("R3 readback", bus_rdata, 32'h0000_A5C3);
        chk("R12 no err on good read", {31'h0, bus_err}, 32'h0);
        @(negedge clk);
        chk("R12 rdata zero when idle", bus_rdata, 32'h0);

        // R4 set
        wr_word(4'h8, 32'h0000_0A0C); exp_out = exp_out | 16'h0A0C;
        chk("R4 set bits", {16'h0, pin_out}, {16'h0, exp_out});
        // R5 clear via upper half
        wr_word(4'h8, 32'h8081_0000); exp_out = exp_out & ~16'h8081;
        chk("R5 clear bits", {16'h0, pin_out}, {16'h0, exp_out});
        // R6 set wins
        wr_word(4'h8, 32'h00F0_00F0); exp_out = exp_out | 16'h00F0;
        chk("R6 set wins", {16'h0, pin_out}, {16'h0, exp_out});
        wr_word(4'h4, 32'h0000_0000); exp_out = 16'h0;
        wr_word(4'h8, 32'h0001_0001); exp_out = 16'h0001;
        chk("R6 set wins from low", {16'h0, pin_out}, {16'h0, exp_out});
        // R7 zero writes
        wr_word(4'h4, 32'h0000_3C5A); exp_out = 16'h3C5A;
        wr_word(4'h8, 32'h0);
        chk("R7 zero setclr", {16'h0, pin_out}, {16'h0, exp_out});
        wr_word(4'hC, 32'h0);
        chk("R7 zero clr", {16'h0, pin_out}, {16'h0, exp_out});
        // R8 clear-only, upper half ignored
        wr_word(4'hC, 32'hFFFF_0418); exp_out = exp_out & ~16'h0418;
        chk("R8 clr only", {16'h0, pin_out}, {16'h0, exp_out});

        // R9
        rd_word(4'h8);
        chk("R9 setclr reads zero", bus_rdata, 32'h0);
        rd_word(4'hC);
        chk("R9 clr reads zero", bus_rdata, 32'h0);
        wr_word(4'h0, 32'h0000_FFFF);
        chk("R9 input write ignored", {16'h0, pin_out}, {16'h0, exp_out});

        // R2 sub-word and misaligned
        for (int sz = 0; sz < 2; sz++) begin
            bus_op(1'b1, 1'b0, 4'h4, 2'(sz), 32'h0000_FFFF);
            chk("R2 subword write pins", {16'h0, pin_out}, {16'h0, exp_out});
            chk("R2 subword write err", {31'h0, bus_err}, 32'h1);
            bus_op(1'b1, 1'b0, 4'h8, 2'(sz), 32'h0000_FFFF);
            chk("R2 subword setclr pins", {16'h0, pin_out}, {16'h0, exp_out});
            bus_op(1'b0, 1'b1, 4'h4, 2'(sz), 32'h0);
            chk("R2 subword read err", {31'h0, bus_err}, 32'h1);
            chk("R2 subword read data", bus_rdata, 32'h0);
        end
        for (int a = 1; a < 4; a++) begin
            bus_op(1'b1, 1'b0, 4'(4 + a), 2'd2, 32'h0000_FFFF);
            chk("R2 misaligned pins", {16'h0, pin_out}, {16'h0, exp_out});
            chk("R2 misaligned err", {31'h0, bus_err}, 32'h1);
        end
        wr_word(4'h4, {16'h0, exp_out});
        chk("R12 err clears after good access", {31'h0, bus_err}, 32'h0);

        // R10 synchronizer delay: hold a read of the input slot open
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        bus_addr = 4'h0; bus_size = 2'd2; bus_rd = 1'b1; pin_in = 16'hBEEF;
        @(negedge clk);
        chk("R10 first edge old", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R10 second edge old", bus_rdata, 32'h0);
        @(negedge clk);
        chk("R10 third edge new", bus_rdata, 32'h0000_BEEF);
        bus_rd = 1'b0;
        @(negedge clk);
        for (int p = 0; p < 16; p++) begin
            pin_in = 16'(1 << p);
            repeat (2) @(negedge clk);
            rd_word(4'h0);
            chk("R10 walking pin", bus_rdata, 32'(1 << p));
        end

        // R11 field load, all 256 values over two backgrounds
        for (int bg = 0; bg < 2; bg++) begin
            exp_out = (bg == 0) ? 16'h0000 : 16'hFFFF;
            wr_word(4'h4, {16'h0, exp_out});
            for (int v = 0; v < 256; v++) begin
                wr_word(4'h8, 32'h7F80_0000 | (32'(v) << 7));
                exp_out = (exp_out & ~16'h7F80) | 16'(v << 7);
                chk("R11 field load", {16'h0, pin_out}, {16'h0, exp_out});
            end
        end

        // mixed sequence against an arithmetic model (R4 R5 R7 R8 R3)
        lfsr = 16'hACE1;
        for (int i = 0; i < 600; i++) begin
            logic [31:0] d;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d = {lfsr ^ 16'h5A5A, {lfsr[7:0], lfsr[15:8]}};
            case (lfsr[1:0])
                2'd0: begin wr_word(4'h4, d); exp_out = d[15:0]; end
                2'd1: begin wr_word(4'h8, d); exp_out = (exp_out & ~d[31:16]) | d[15:0]; end
                2'd2: begin wr_word(4'hC, d); exp_out = exp_out & ~d[15:0]; end
                default: begin
                    rd_word(4'h4);
                    chk("R3 model readback", bus_rdata, {16'h0, exp_out});
                end
            endcase
            chk("R7 model pins", {16'h0, pin_out}, {16'h0, exp_out});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule